// File: doc/BRIEF.md
# DMA Request Source Selector

This block decides which on-chip event raises the request line of one DMA channel. Software programs an 8-bit control register with a 4-bit cause code and a bank bit. The bank bit chooses between two readings of that code. The basic bank covers fourteen peripheral event pulses, a falling edge on an active-low external pin, and a software trigger. The extended bank covers two serial-unit event pulses and a mode that reacts to either edge of the external pin. The block drives one single-cycle request pulse to the channel.

Every event input is a one-cycle pulse, and so is the request output. The request carries no valid/ready handshake and cannot be held off. A channel that is busy when a pulse arrives must latch the pulse itself. The external pin is asynchronous, so it passes through a flop synchronizer before edge detection. Each qualifying edge therefore gives exactly one request. Bit 7 of the register is a write-only strobe that requests a transfer immediately. It acts only when the value being written selects the software-trigger cause in the basic bank.

Top module: `dma_req_select`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00 and `dma_req` is low.
- R2: A write stores bits 6 and 3..0. Bits 7, 5 and 4 always read as 0, so writing 0xFF reads back 0x4F.
- R3: With bit 6 = 0 and code n in 2..15, a pulse on `evt_src[n-2]` gives `dma_req` high for exactly the next cycle. Codes 2..6 are timer A0..A4, 7..9 are timer B0..B2, 10 is UART0 transmit, 11 is UART0 receive, 12 is UART2 transmit, 13 is UART2 receive, 14 is A-D done and 15 is UART1 receive.
- R4: With bit 6 = 1, code 5 selects `ext_evt[0]` (serial unit 3) and code 6 selects `ext_evt[1]` (serial unit 4). The request follows one cycle after the pulse.
- R5: With bit 6 = 1, every code except 5, 6 and 7 produces no request, whatever the inputs do.
- R6: With bit 6 = 0 and code 0, a high-to-low change of `ext_pin_n` gives one request pulse. The pulse appears after the third rising clock edge that follows the change.
- R7: With bit 6 = 1 and code 7, both a falling and a rising change of `ext_pin_n` each give one request pulse, with the same latency as R6.
- R8: Writing a value with bit 7 = 1, bit 6 = 0 and code 0001 gives a request in the cycle after the write. Bit 7 has no effect with any other bit 6 or code value, and it reads back as 0.
- R9: A pulse on an event input that the current setting does not select gives no request.
- R10: Rewriting the select field while `ext_pin_n` is steady gives no request.
- R11: With bit 6 = 0 and code 0, a low-to-high change of `ext_pin_n` gives no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| evt_src | input | 14 | Basic event pulses; bit i is the cause for code i+2 |
| ext_evt | input | 2 | Extended event pulses (serial unit 3, serial unit 4) |
| ext_pin_n | input | 1 | Asynchronous active-low external pin |
| dma_req | output | 1 | Single-cycle request to the DMA channel |

## Verification
A corrupted stored code or bank bit shows up at `reg_rdata` in the cycle after the write. It also shows up at the next event pulse, as a request on the wrong source or a missing one one cycle later. A fault in the synchronizer or in the edge-history flop shows up only when the pin moves. It appears as a pulse at the wrong latency, a double pulse, or a request on the wrong edge direction, within three cycles of the pin change. A software strobe that is decoded wrongly appears on `dma_req` in the cycle right after the write.

// File: rtl/dma_sel_pkg.sv
package dma_sel_pkg;
  localparam int CODE_W     = 4;
  localparam int NUM_CODES  = 1 << CODE_W;
  localparam int FIRST_EVT  = 2;
  localparam int NUM_EVT    = NUM_CODES - FIRST_EVT;
  localparam int NUM_XEVT   = 2;
  localparam int XEVT_FIRST = 5;
  localparam int BANK_BIT   = 6;
  localparam int STROBE_BIT = 7;

  localparam logic [CODE_W-1:0] CODE_PIN_FALL = 4'd0;
  localparam logic [CODE_W-1:0] CODE_SOFT     = 4'd1;
  localparam logic [CODE_W-1:0] XCODE_PIN_ANY = 4'd7;

  localparam logic [7:0] STORE_MASK = 8'h4F;

  typedef struct packed {
    logic              bank_ext;
    logic [CODE_W-1:0] code;
  } sel_t;
endpackage

// File: rtl/dma_sel_regs.sv
module dma_sel_regs
  import dma_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output sel_t       sel,
  output logic       soft_hit
);
  logic [7:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata & STORE_MASK;
  end

  assign rdata        = ctrl_q;
  assign sel.bank_ext = ctrl_q[BANK_BIT];
  assign sel.code     = ctrl_q[CODE_W-1:0];

  // the strobe is judged against the value being written, not the old one
  assign soft_hit = wr_en && wdata[STROBE_BIT] && !wdata[BANK_BIT]
                    && (wdata[CODE_W-1:0] == CODE_SOFT);
endmodule

// File: rtl/dma_sel_pin_edge.sv
module dma_sel_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              hist_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b1;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b1;
    else        hist_q <= sync_q[STAGES-1];
  end

  assign fall = hist_q && !sync_q[STAGES-1];
  assign rise = !hist_q && sync_q[STAGES-1];
endmodule

// File: rtl/dma_sel_mux.sv
module dma_sel_mux
  import dma_sel_pkg::*;
(
  input  sel_t                sel,
  input  logic [NUM_EVT-1:0]  evt_src,
  input  logic [NUM_XEVT-1:0] ext_evt,
  input  logic                pin_fall,
  input  logic                pin_rise,
  output logic                hit
);
  logic [CODE_W-1:0] evt_idx;
  logic              basic_hit;
  logic              ext_hit;
  logic [NUM_XEVT-1:0] xmatch;

  assign evt_idx = sel.code - CODE_W'(FIRST_EVT);

  always_comb begin
    if (sel.code == CODE_PIN_FALL)  basic_hit = pin_fall;
    else if (sel.code == CODE_SOFT) basic_hit = 1'b0;
    else                            basic_hit = evt_src[evt_idx];
  end

  generate
    for (genvar x = 0; x < NUM_XEVT; x++) begin : g_xev
      assign xmatch[x] = (sel.code == CODE_W'(XEVT_FIRST + x)) && ext_evt[x];
    end
  endgenerate

  assign ext_hit = (|xmatch) ||
                   ((sel.code == XCODE_PIN_ANY) && (pin_fall || pin_rise));

  assign hit = sel.bank_ext ? ext_hit : basic_hit;
endmodule

// File: rtl/dma_req_select.sv
module dma_req_select
  import dma_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic [NUM_EVT-1:0]  evt_src,
  input  logic [NUM_XEVT-1:0] ext_evt,
  input  logic                ext_pin_n,
  output logic                dma_req
);
  sel_t sel;
  logic soft_hit, sel_hit, pin_fall, pin_rise;

  dma_sel_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .rdata(reg_rdata), .sel(sel), .soft_hit(soft_hit)
  );

  dma_sel_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n), .fall(pin_fall), .rise(pin_rise)
  );

  dma_sel_mux u_mux (
    .sel(sel), .evt_src(evt_src), .ext_evt(ext_evt),
    .pin_fall(pin_fall), .pin_rise(pin_rise), .hit(sel_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_req <= 1'b0;
    else        dma_req <= sel_hit || soft_hit;
  end
endmodule

// File: rtl/dma_req_select_chk.sv
module dma_req_select_chk
  import dma_sel_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr_en,
  input logic [7:0]          reg_wdata,
  input logic [7:0]          reg_rdata,
  input logic [NUM_EVT-1:0]  evt_src,
  input logic [NUM_XEVT-1:0] ext_evt,
  input logic                ext_pin_n,
  input logic                dma_req
);
  logic [3:0] cur_code;
  logic [3:0] cur_idx;
  logic       cur_ext;
  assign cur_code = reg_rdata[3:0];
  assign cur_idx  = cur_code - 4'd2;
  assign cur_ext  = reg_rdata[6];

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] == 1'b0 && reg_rdata[5:4] == 2'b00);

  assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_rdata == {1'b0, $past(reg_wdata[6]), 2'b00, $past(reg_wdata[3:0])});

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(reg_rdata));

  assert_basic_evt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && !cur_ext && cur_code >= 4'd2 && evt_src[cur_idx]) |=> dma_req);

  assert_ext_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && cur_ext && ((cur_code == 4'd5 && ext_evt[0]) ||
                               (cur_code == 4'd6 && ext_evt[1]))) |=> dma_req);

  assert_ext_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && cur_ext && cur_code != 4'd5 && cur_code != 4'd6 && cur_code != 4'd7)
      |=> !dma_req);

  assert_soft_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wdata[7] && !reg_wdata[6] && reg_wdata[3:0] == 4'd1) |=> dma_req);

  // the external pin alone can never raise two requests in a row under code 0
  assert_pin_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && !cur_ext && cur_code == 4'd0 && dma_req && $stable(ext_pin_n))
      |=> !dma_req);
endmodule

bind dma_req_select dma_req_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .evt_src(evt_src), .ext_evt(ext_evt),
  .ext_pin_n(ext_pin_n), .dma_req(dma_req)
);

// File: tb/dma_req_select_tb_top.sv
`timescale 1ns/1ps
module dma_req_select_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [13:0] evt_src = '0;
  logic [1:0]  ext_evt = '0;
  logic        ext_pin_n = 1'b1;
  logic        dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_req_select dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_src(evt_src), .ext_evt(ext_evt),
    .ext_pin_n(ext_pin_n), .dma_req(dma_req)
  );

  typedef struct packed {
    logic        ext;
    logic [3:0]  code;
    logic [13:0] evt;
    logic [1:0]  xev;
    logic        exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd2,  14'h0001, 2'b00, 1'b1},  // R3 timer A0
    '{1'b0, 4'd15, 14'h2000, 2'b00, 1'b1},  // R3 UART1 receive
    '{1'b0, 4'd9,  14'h0080, 2'b00, 1'b1},  // R3 timer B2
    '{1'b0, 4'd9,  14'h0040, 2'b00, 1'b0},  // R9 neighbour bit
    '{1'b0, 4'd10, 14'h3EFF, 2'b11, 1'b0},  // R9 all but own bit
    '{1'b1, 4'd5,  14'h0000, 2'b01, 1'b1},  // R4 serial 3
    '{1'b1, 4'd6,  14'h0000, 2'b10, 1'b1},  // R4 serial 4
    '{1'b1, 4'd6,  14'h0000, 2'b01, 1'b0},  // R9 wrong extended pulse
    '{1'b1, 4'd3,  14'h3FFF, 2'b11, 1'b0},  // R5 unused extended code
    '{1'b1, 4'd15, 14'h3FFF, 2'b11, 1'b0},  // R5 unused extended code
    '{1'b0, 4'd4,  14'h0000, 2'b11, 1'b0},  // R9 extended pulses in basic bank
    '{1'b1, 4'd5,  14'h0008, 2'b00, 1'b0}   // R9 basic pulse in extended bank
  };

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // write at a negedge; returns dma_req seen one cycle after the write
  task automatic write_reg(input logic [7:0] v, output logic req_after);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
    req_after = dma_req;
  endtask

  // move the pin and count request pulses over six cycles
  task automatic pin_move(input logic lvl, input int exp_cnt, input string req);
    int cnt = 0;
    int first = -1;
    @(negedge clk);
    ext_pin_n = lvl;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (dma_req) begin
        cnt++;
        if (first < 0) first = k;
      end
    end
    check(8'(cnt), 8'(exp_cnt), req);
    if (exp_cnt == 1) check(8'(first), 8'd3, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic r;
    repeat (3) @(negedge clk);
    check(reg_rdata, 8'h00, "R1 rdata");
    check({7'd0, dma_req}, 8'd0, "R1 dma_req");
    rst_n = 1'b1;
    @(negedge clk);
    check(reg_rdata, 8'h00, "R1 rdata after release");

    for (int i = 0; i < NV; i++) begin
      write_reg({1'b0, VECS[i].ext, 2'b00, VECS[i].code}, r);
      @(negedge clk);
      evt_src = VECS[i].evt; ext_evt = VECS[i].xev;
      @(negedge clk);
      evt_src = '0; ext_evt = '0;
      check({7'd0, dma_req}, {7'd0, VECS[i].exp}, $sformatf("R3/R4/R5/R9 vec %0d", i));
      @(negedge clk);
      check({7'd0, dma_req}, 8'd0, $sformatf("R3 single pulse vec %0d", i));
    end

    // R2 readback masking
    write_reg(8'hFF, r);
    check(reg_rdata, 8'h4F, "R2 write FF");
    write_reg(8'h30, r);
    check(reg_rdata, 8'h00, "R2 write 30");

    // R8 software strobe
    write_reg(8'h81, r);
    check({7'd0, r}, 8'd1, "R8 strobe fires");
    check(reg_rdata, 8'h01, "R8 bit7 reads 0");
    @(negedge clk);
    check({7'd0, dma_req}, 8'd0, "R8 single pulse");
    write_reg(8'hC1, r);
    check({7'd0, r}, 8'd0, "R8 strobe in extended bank");
    write_reg(8'h82, r);
    check({7'd0, r}, 8'd0, "R8 strobe with code 2");
    write_reg(8'h01, r);
    check({7'd0, r}, 8'd0, "R8 code 1 without strobe");

    // R6 / R11 basic pin falling edge
    write_reg(8'h00, r);
    pin_move(1'b0, 1, "R6 falling edge");
    pin_move(1'b1, 0, "R11 rising edge ignored");

    // R7 both edges in extended mode
    write_reg(8'h47, r);
    pin_move(1'b0, 1, "R7 falling edge");
    pin_move(1'b1, 1, "R7 rising edge");

    // R10 select changes while pin steady (high, then low)
    begin
      int cnt = 0;
      write_reg(8'h00, r); if (r) cnt++;
      write_reg(8'h47, r); if (r) cnt++;
      write_reg(8'h00, r); if (r) cnt++;
      repeat (4) begin @(negedge clk); if (dma_req) cnt++; end
      check(8'(cnt), 8'd0, "R10 reselect pin high");
    end
    write_reg(8'h45, r);
    pin_move(1'b0, 0, "R9 pin with serial code");
    begin
      int cnt = 0;
      write_reg(8'h47, r); if (r) cnt++;
      write_reg(8'h00, r); if (r) cnt++;
      write_reg(8'h47, r); if (r) cnt++;
      repeat (4) begin @(negedge clk); if (dma_req) cnt++; end
      check(8'(cnt), 8'd0, "R10 reselect pin low");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule